// File: doc/BRIEF.md
# Data-Path Control Register with Status-Gated Writes

This block is the control register for the data path of a card interface. Software programs it through a simple write/read port. It holds these fields:

- transfer enable, direction and mode
- a 4-bit block-size code
- read-wait start, stop and mode
- an I/O interrupt enable and a boot-acknowledge enable
- a FIFO flush request

Each field has its own write permission, which depends on two live status flags. One flag reports that the data-path sequencer is active. The other reports that DMA is enabled.

The configuration fields are locked while the sequencer is active. The flush request can only be written while the sequencer is active and DMA is off. The two read-wait trigger bits can be written at any time. A write carrying a mix of permitted and locked fields updates only the permitted ones.

The sequencer clears the enable bit when a transfer completes, and clears the read-wait stop bit when it leaves read-wait. It does this through dedicated strobes, and a strobe wins over a software write to the same bit in the same cycle. A pending flush request waits for an error or hold condition. It then produces a one-cycle flush pulse and clears itself.

Top module: `dpath_ctrl_reg`

## Requirements
- R1: The enable (bit 0), direction (bit 1), mode (bit 2), block-size code (bits 7:4), read-wait mode (bit 10), I/O interrupt enable (bit 11) and boot-ack enable (bit 12) take the written value only when `seq_active_i` is 0; otherwise they keep their value.
- R2: Read-wait start (bit 8) and read-wait stop (bit 9) take the written value on every write, whatever the status flags.
- R3: In one write, the permitted fields update and the locked fields stay unchanged.
- R4: `xfer_done_i` clears the enable bit on the next edge, even when a permitted write sets it in the same cycle.
- R5: `rw_exit_i` clears read-wait stop on the next edge, even when a write sets it in the same cycle.
- R6: The flush request (bit 16) takes a write only when `dma_en_i` is 0 and `seq_active_i` is 1.
- R7: A stored flush request stays pending until `xfer_err_i` or `xfer_hold_i` is sampled high. At that edge `flush_o` goes high for exactly one cycle and the stored bit clears; the clear wins over a same-cycle write.
- R8: After reset every field is 0. `rd_data_o` returns the stored fields at the bit positions above, with all other bits 0, and each field output equals its stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current register contents |
| seq_active_i | input | 1 | Sequencer active flag |
| dma_en_i | input | 1 | DMA enable flag |
| xfer_done_i | input | 1 | Hardware clear of transfer enable |
| rw_exit_i | input | 1 | Hardware clear of read-wait stop |
| xfer_err_i | input | 1 | Transfer error condition |
| xfer_hold_i | input | 1 | Transfer hold condition |
| flush_o | output | 1 | One-cycle FIFO flush pulse |
| xfer_en_o | output | 1 | Transfer enable |
| dir_o | output | 1 | Transfer direction |
| mode_o | output | 1 | Transfer mode |
| blk_code_o | output | 4 | Block-size code |
| rw_start_o | output | 1 | Read-wait start |
| rw_stop_o | output | 1 | Read-wait stop |
| rw_mode_o | output | 1 | Read-wait mode |
| io_irq_en_o | output | 1 | I/O interrupt enable |
| boot_ack_en_o | output | 1 | Boot-acknowledge enable |

## Verification
The hardest case to reach is a flush. The request must first be written inside the narrow window where the sequencer is active and DMA is off. It must then be left pending across cycles with neither error nor hold high, and only afterwards consumed. The stimulus sweeps every combination of the two status flags against several write patterns. It then builds this sequence explicitly, including a same-cycle write that races the consumption. It also fires each hardware clear together with a write that sets the same bit.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int DW        = 32;
  localparam int BLK_W     = 4;
  localparam int P_EN      = 0;
  localparam int P_DIR     = 1;
  localparam int P_MODE    = 2;
  localparam int P_BLK     = 4;
  localparam int P_RWSTART = 8;
  localparam int P_RWSTOP  = 9;
  localparam int P_RWMODE  = 10;
  localparam int P_IOIRQ   = 11;
  localparam int P_BOOTACK = 12;
  localparam int P_FLUSH   = 16;

  typedef struct packed {
    logic             xfer_en;
    logic             dir;
    logic             mode;
    logic [BLK_W-1:0] blk;
    logic             rw_start;
    logic             rw_stop;
    logic             rw_mode;
    logic             io_irq_en;
    logic             boot_ack_en;
    logic             flush;
  } dpc_fields_t;

  function automatic logic [DW-1:0] dpc_pack(dpc_fields_t f);
    logic [DW-1:0] w;
    w = '0;
    w[P_EN]                 = f.xfer_en;
    w[P_DIR]                = f.dir;
    w[P_MODE]               = f.mode;
    w[P_BLK +: BLK_W]       = f.blk;
    w[P_RWSTART]            = f.rw_start;
    w[P_RWSTOP]             = f.rw_stop;
    w[P_RWMODE]             = f.rw_mode;
    w[P_IOIRQ]              = f.io_irq_en;
    w[P_BOOTACK]            = f.boot_ack_en;
    w[P_FLUSH]              = f.flush;
    return w;
  endfunction
endpackage

// File: rtl/dpc_wr_gate.sv
module dpc_wr_gate (
  input  logic wr_en_i,
  input  logic seq_active_i,
  input  logic dma_en_i,
  output logic we_lock_o,
  output logic we_free_o,
  output logic we_flush_o
);
  always_comb begin
    we_lock_o  = wr_en_i & ~seq_active_i;
    we_free_o  = wr_en_i;
    we_flush_o = wr_en_i & seq_active_i & ~dma_en_i;
  end
endmodule

// File: rtl/dpc_field.sv
module dpc_field #(
  parameter int W       = 1,
  parameter bit HAS_CLR = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic clr_eff;

  generate
    if (HAS_CLR) begin : g_clr
      assign clr_eff = clr_i;
    end else begin : g_noclr
      assign clr_eff = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (clr_eff) q_o <= '0;   // hardware clear wins
    else if (we_i)    q_o <= d_i;
  end
endmodule

// File: rtl/dpc_flush.sv
module dpc_flush (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic d_i,
  input  logic err_i,
  input  logic hold_i,
  output logic req_o,
  output logic pulse_o
);
  logic fire;

  assign fire = req_o & (err_i | hold_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= fire;
      if (fire)      req_o <= 1'b0;  // consumption beats a racing write
      else if (we_i) req_o <= d_i;
    end
  end
endmodule

// File: rtl/dpath_ctrl_reg.sv
module dpath_ctrl_reg
  import dpc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic             seq_active_i,
  input  logic             dma_en_i,
  input  logic             xfer_done_i,
  input  logic             rw_exit_i,
  input  logic             xfer_err_i,
  input  logic             xfer_hold_i,
  output logic             flush_o,
  output logic             xfer_en_o,
  output logic             dir_o,
  output logic             mode_o,
  output logic [BLK_W-1:0] blk_code_o,
  output logic             rw_start_o,
  output logic             rw_stop_o,
  output logic             rw_mode_o,
  output logic             io_irq_en_o,
  output logic             boot_ack_en_o
);
  logic        we_lock, we_free, we_flush;
  dpc_fields_t f;

  dpc_wr_gate u_gate (
    .wr_en_i     (wr_en_i),
    .seq_active_i(seq_active_i),
    .dma_en_i    (dma_en_i),
    .we_lock_o   (we_lock),
    .we_free_o   (we_free),
    .we_flush_o  (we_flush)
  );

  dpc_field #(.W(1), .HAS_CLR(1'b1)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_lock),
    .d_i(wr_data_i[P_EN]), .clr_i(xfer_done_i), .q_o(f.xfer_en));
  dpc_field #(.W(1)) u_dir (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_lock),
    .d_i(wr_data_i[P_DIR]), .clr_i(1'b0), .q_o(f.dir));
  dpc_field #(.W(1)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_lock),
    .d_i(wr_data_i[P_MODE]), .clr_i(1'b0), .q_o(f.mode));
  dpc_field #(.W(BLK_W)) u_blk (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_lock),
    .d_i(wr_data_i[P_BLK +: BLK_W]), .clr_i(1'b0), .q_o(f.blk));
  dpc_field #(.W(1)) u_rwstart (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_free),
    .d_i(wr_data_i[P_RWSTART]), .clr_i(1'b0), .q_o(f.rw_start));
  dpc_field #(.W(1), .HAS_CLR(1'b1)) u_rwstop (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_free),
    .d_i(wr_data_i[P_RWSTOP]), .clr_i(rw_exit_i), .q_o(f.rw_stop));
  dpc_field #(.W(1)) u_rwmode (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_lock),
    .d_i(wr_data_i[P_RWMODE]), .clr_i(1'b0), .q_o(f.rw_mode));
  dpc_field #(.W(1)) u_ioirq (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_lock),
    .d_i(wr_data_i[P_IOIRQ]), .clr_i(1'b0), .q_o(f.io_irq_en));
  dpc_field #(.W(1)) u_bootack (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_lock),
    .d_i(wr_data_i[P_BOOTACK]), .clr_i(1'b0), .q_o(f.boot_ack_en));

  dpc_flush u_flush (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_flush),
    .d_i    (wr_data_i[P_FLUSH]),
    .err_i  (xfer_err_i),
    .hold_i (xfer_hold_i),
    .req_o  (f.flush),
    .pulse_o(flush_o)
  );

  always_comb begin
    rd_data_o     = dpc_pack(f);
    xfer_en_o     = f.xfer_en;
    dir_o         = f.dir;
    mode_o        = f.mode;
    blk_code_o    = f.blk;
    rw_start_o    = f.rw_start;
    rw_stop_o     = f.rw_stop;
    rw_mode_o     = f.rw_mode;
    io_irq_en_o   = f.io_irq_en;
    boot_ack_en_o = f.boot_ack_en;
  end
endmodule

// File: rtl/dpc_chk.sv
module dpc_chk
  import dpc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [DW-1:0]    rd_data_o,
  input logic             seq_active_i,
  input logic             dma_en_i,
  input logic             xfer_done_i,
  input logic             rw_exit_i,
  input logic             xfer_err_i,
  input logic             xfer_hold_i,
  input logic             flush_o,
  input logic             rw_start_o
);
  logic [DW-1:0] lock_view;
  assign lock_view = rd_data_o & ((DW'(1) << P_DIR) | (DW'(1) << P_MODE) |
                                  (DW'(((1 << BLK_W) - 1)) << P_BLK) |
                                  (DW'(1) << P_RWMODE) | (DW'(1) << P_IOIRQ) |
                                  (DW'(1) << P_BOOTACK));

  AST_LOCKED_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_active_i |=> $stable(lock_view)); // R1

  AST_EN_NO_SET_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_active_i && !rd_data_o[P_EN]) |=> !rd_data_o[P_EN]); // R1

  AST_RWSTART_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rw_start_o == $past(wr_data_i[P_RWSTART]))); // R2

  AST_EN_HW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> !rd_data_o[P_EN]); // R4

  AST_STOP_HW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_exit_i |=> !rd_data_o[P_RWSTOP]); // R5

  AST_FLUSH_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dma_en_i || !seq_active_i) && !rd_data_o[P_FLUSH]) |=> !rd_data_o[P_FLUSH]); // R6

  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o); // R7

  AST_FLUSH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> ($past(rd_data_o[P_FLUSH]) && $past(xfer_err_i || xfer_hold_i))); // R7

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !rd_data_o[P_FLUSH]); // R7
endmodule

bind dpath_ctrl_reg dpc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_data_i   (wr_data_i),
  .rd_data_o   (rd_data_o),
  .seq_active_i(seq_active_i),
  .dma_en_i    (dma_en_i),
  .xfer_done_i (xfer_done_i),
  .rw_exit_i   (rw_exit_i),
  .xfer_err_i  (xfer_err_i),
  .xfer_hold_i (xfer_hold_i),
  .flush_o     (flush_o),
  .rw_start_o  (rw_start_o)
);

// File: tb/tb_dpath_ctrl_reg.sv
module tb_dpath_ctrl_reg;
  localparam logic [31:0] M_LOCK  = 32'h0000_1CF7;
  localparam logic [31:0] M_FREE  = 32'h0000_0300;
  localparam logic [31:0] M_FLUSH = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, act = 1'b0, dma = 1'b0;
  logic        done = 1'b0, rwx = 1'b0, err = 1'b0, hold = 1'b0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic        flush, en, dir, mode, rws, rwp, rwm, ioe, bae;
  logic [3:0]  blk;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] exp_reg = '0;

  always #10 clk = ~clk;

  dpath_ctrl_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wdat),
    .rd_data_o(rdat), .seq_active_i(act), .dma_en_i(dma),
    .xfer_done_i(done), .rw_exit_i(rwx), .xfer_err_i(err), .xfer_hold_i(hold),
    .flush_o(flush), .xfer_en_o(en), .dir_o(dir), .mode_o(mode),
    .blk_code_o(blk), .rw_start_o(rws), .rw_stop_o(rwp), .rw_mode_o(rwm),
    .io_irq_en_o(ioe), .boot_ack_en_o(bae)
  );

  task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act_v, exp_v);
    end
  endtask

  // One cycle of stimulus; expected state computed from the requirements.
  task automatic step(input string req, input logic w, input logic [31:0] d,
                      input logic a, input logic m, input logic dn, input logic rx,
                      input logic e, input logic h);
    logic [31:0] nx;
    logic        pulse_exp;
    wr_en = w; wdat = d; act = a; dma = m; done = dn; rwx = rx; err = e; hold = h;
    nx = exp_reg;
    pulse_exp = exp_reg[16] & (e | h);
    if (w && !a)       nx = (nx & ~M_LOCK)  | (d & M_LOCK);
    if (w)             nx = (nx & ~M_FREE)  | (d & M_FREE);
    if (w && a && !m)  nx = (nx & ~M_FLUSH) | (d & M_FLUSH);
    if (dn)            nx[0]  = 1'b0;
    if (rx)            nx[9]  = 1'b0;
    if (pulse_exp)     nx[16] = 1'b0;
    exp_reg = nx;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; done = 1'b0; rwx = 1'b0; err = 1'b0; hold = 1'b0;
    check(req, rdat, exp_reg);
    check({req, " pulse"}, {31'b0, flush}, {31'b0, pulse_exp});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'h5555_5555;
    pats[3] = 32'hAAAA_AAAA; pats[4] = 32'h0001_0A5A; pats[5] = 32'h0000_14F3;

    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 reset rd", rdat, 32'h0);
    check("R8 reset flush", {31'b0, flush}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R6: sweep status flags against write patterns
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 6; p++) begin
        step("R3 sweep", 1'b1, pats[p], s[0], s[1], 1'b0, 1'b0, 1'b0, 1'b0);
      end
    end

    // R8 field outputs agree with register word
    step("R1 load all", 1'b1, 32'h0000_1FF7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 fields", {16'b0, 3'b0, bae, ioe, rwm, rwp, rws, blk, 1'b0, mode, dir, en},
          exp_reg & 32'h0000_FFFF);
    step("R1 locked clear", 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R2 free clear", 1'b1, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    // R4 hardware clear of enable, alone and racing a permitted write
    step("R4 set en", 1'b1, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R4 done alone", 1'b0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step("R4 race", 1'b1, 32'h1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);

    // R5 hardware clear of read-wait stop
    step("R5 set stop", 1'b1, 32'h200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R5 exit", 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R5 race", 1'b1, 32'h300, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

    // R6 R7 flush: pend, hold idle, consume via error then via hold
    step("R6 clr", 1'b1, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R6 dma blocks", 1'b1, M_FLUSH, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R6 idle blocks", 1'b1, M_FLUSH, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R6 set", 1'b1, M_FLUSH, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++)
      step("R7 pending", 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R7 err fire", 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R7 no repeat", 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R6 set again", 1'b1, M_FLUSH, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R7 hold race", 1'b1, M_FLUSH, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R7 after race", 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R7 no request", 1'b0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule